// File: doc/BRIEF.md
# Recursive Sliding-Window Product Integrator

This block is the demodulating integrator of a digital lock-in detector. Each accepted input sample is multiplied by one entry of a periodic reference. The block does not hold the reference table. It drives a phase index that counts accepted samples modulo M, and the surrounding logic returns the table entry for that index on the same cycle. The block then keeps a running mean of the last N products and emits one result for every accepted sample once the window holds N samples.

The mean is not recomputed from scratch. An N-entry circular buffer stores past products. On every accepted sample the block adds the newest product to a wide accumulator and subtracts the product that is about to be overwritten. Until N samples have entered, the retiring entry counts as zero. The accumulator is exact fixed point and wide enough for N worst-case products, so the recursion never drifts from a direct N-term sum.

When N is a power of two, the result is the accumulator shifted right arithmetically by log2(N) and held at product width. For any other N the raw window sum comes out at full accumulator width.

Both data interfaces use valid/ready. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. There is one output register. `in_ready` is high whenever that register is empty or is being drained on the same edge, so back-pressure on the output stalls the input one-for-one.

Top module: `sliding_product_integrator`

## Requirements
- R1: After reset `out_valid` is 0, `ref_idx` is 0, `in_ready` is 1, and the window is empty.
- R2: `ref_idx` advances by one on every accepted sample, wrapping from M-1 to 0. It does not change on any other cycle and always stays below M.
- R3: Each product is the full-precision signed product of `in_data` and `ref_data` (both two's complement), with no truncation.
- R4: The first N-1 accepted samples after reset produce no output. The N-th and every later accepted sample produce exactly one output, in order.
- R5: With N a power of two, each output equals floor(S / N), where S is the exact sum of the N most recent products. This is an arithmetic right shift that rounds toward minus infinity. The result stays exact over arbitrarily long runs.
- R6: `in_ready` equals (not `out_valid`) or `out_ready`. When `in_valid` is low, `in_data` has no effect on any later output.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R8: A full window of worst-case products does not overflow. With DW=RW=8, inputs of -128 and references of -128 give an output of 16384. Inputs of 127 with references of -128 give -16256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DW | Signed input sample |
| ref_idx | output | IW | Reference phase index, 0 to M-1 |
| ref_data | input | RW | Signed reference value for `ref_idx` |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | OW | Scaled window mean (PW bits) or raw sum (AW bits) |

## Verification
On every cycle the assertions check three things:
- the phase index stays in range and steps by one only on an accepted sample (R2, R6);
- a stalled result holds steady (R7);
- no result appears before N samples have been accepted since reset (R4).

Only the bench's scenarios can show that each value is the exact floor mean of the last N products. They exercise:
- long runs with irregular valid and ready patterns;
- garbage data on idle cycles;
- a mid-run reset followed by a refill;
- full windows of extreme products, which show the accumulator never overflows or drifts.

// File: rtl/lockin_integ_pkg.sv
package lockin_integ_pkg;
  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int idx_width(input int v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/ref_phase_counter.sv
module ref_phase_counter #(
  parameter int M  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(M - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/product_delay_line.sv
module product_delay_line #(
  parameter int N  = 8,
  parameter int PW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic signed [PW-1:0] wr_data,
  output logic signed [PW-1:0] retire_data,
  output logic                 window_done
);
  localparam int PTRW = lockin_integ_pkg::idx_width(N);
  localparam int CNTW = $clog2(N + 1);
  localparam logic [PTRW-1:0] PLAST = PTRW'(N - 1);
  localparam logic [CNTW-1:0] FULL  = CNTW'(N);
  localparam logic [CNTW-1:0] ALMOST = CNTW'(N - 1);

  logic signed [PW-1:0] slots [N];
  logic [PTRW-1:0] ptr;
  logic [CNTW-1:0] fill;

  // The slot about to be overwritten carries the product from N samples back;
  // before the window has wrapped once it counts as zero.
  assign retire_data = (fill == FULL) ? slots[ptr] : '0;
  assign window_done = (fill >= ALMOST);

  always_ff @(posedge clk) begin
    if (wr_en) slots[ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      fill <= '0;
    end else if (wr_en) begin
      ptr <= (ptr == PLAST) ? '0 : ptr + 1'b1;
      if (fill != FULL) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/window_accumulator.sv
module window_accumulator #(
  parameter int PW  = 16,
  parameter int AW  = 20,
  parameter int OW  = 16,
  parameter int LGN = 3,
  parameter bit SHIFT_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic signed [PW-1:0] newest,
  input  logic signed [PW-1:0] oldest,
  input  logic                 window_done,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic        [OW-1:0] out_data
);
  logic signed [AW-1:0] acc, acc_nx, scaled;

  assign acc_nx = acc + AW'(newest) - AW'(oldest);

  generate
    if (SHIFT_OUT) begin : g_shift
      assign scaled = acc_nx >>> LGN;
    end else begin : g_raw
      assign scaled = acc_nx;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      acc       <= acc_nx;
      out_valid <= window_done;
      if (window_done) out_data <= scaled[OW-1:0];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sliding_product_integrator.sv
module sliding_product_integrator #(
  parameter int DW = 8,
  parameter int RW = 8,
  parameter int N  = 8,
  parameter int M  = 5,
  localparam int PW  = DW + RW,
  localparam int IW  = lockin_integ_pkg::idx_width(M),
  localparam int LGN = lockin_integ_pkg::idx_width(N),
  localparam bit POW2 = lockin_integ_pkg::is_pow2(N),
  localparam int AW  = PW + LGN + 1,
  localparam int OW  = POW2 ? PW : AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic [IW-1:0] ref_idx,
  input  logic [RW-1:0] ref_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data
);
  logic                 fire;
  logic signed [PW-1:0] product, retired;
  logic                 window_done;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign product  = $signed(in_data) * $signed(ref_data);

  ref_phase_counter #(.M(M), .IW(IW)) u_phase (
    .clk(clk), .rst_n(rst_n), .adv(fire), .idx(ref_idx)
  );

  product_delay_line #(.N(N), .PW(PW)) u_delay (
    .clk(clk), .rst_n(rst_n), .wr_en(fire), .wr_data(product),
    .retire_data(retired), .window_done(window_done)
  );

  window_accumulator #(
    .PW(PW), .AW(AW), .OW(OW), .LGN(LGN), .SHIFT_OUT(POW2)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .fire(fire), .newest(product),
    .oldest(retired), .window_done(window_done), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/sliding_product_integrator_chk.sv
module sliding_product_integrator_chk #(
  parameter int M  = 5,
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [IW-1:0] ref_idx,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data
);
  localparam int CW = $clog2(N + 1);
  logic          took;
  logic [CW-1:0] seen;

  assign took = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                    seen <= '0;
    else if (took && seen != CW'(N)) seen <= seen + 1'b1;
  end

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_idx < IW'(M));

  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> ref_idx == (($past(ref_idx) == IW'(M - 1)) ? '0 : $past(ref_idx) + 1'b1));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> $stable(ref_idx));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_fill_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen == CW'(N));
endmodule

bind sliding_product_integrator sliding_product_integrator_chk #(
  .M(M), .N(N), .IW(IW), .OW(OW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ref_idx(ref_idx), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/tb_sliding_product_integrator.sv
`timescale 1ns/1ps
module tb_sliding_product_integrator;
  localparam int DW = 8, RW = 8, N = 8, M = 5;
  localparam int PW = 16, OW = 16, IW = 3, LGN = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [DW-1:0] in_data = '0;
  logic [IW-1:0] ref_idx;
  logic [RW-1:0] ref_data;
  logic [OW-1:0] out_data;

  int checks = 0, fails = 0;
  bit xmode = 0, done = 0;
  longint prods [0:4095];
  longint expq  [0:4095];
  int k = 0, head = 0, tail = 0, outs = 0;
  bit held_v = 0;
  logic [OW-1:0] held;
  longint last_out = 0;

  function automatic logic signed [RW-1:0] reftab(input int i, input bit x);
    if (x) return -8'sd128;
    case (i)
      0: return 8'sd127;
      1: return -8'sd128;
      2: return 8'sd37;
      3: return -8'sd90;
      default: return 8'sd5;
    endcase
  endfunction

  assign ref_data = reftab(int'(ref_idx), xmode);

  sliding_product_integrator #(.DW(DW), .RW(RW), .N(N), .M(M)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ref_idx(ref_idx), .ref_data(ref_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [DW-1:0] d, input bit r);
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = r;
    #1;
    if (held_v) begin
      check(out_valid === 1'b1, "R7 valid held", longint'(out_valid), 1);
      check(out_data === held, "R7 data held", longint'($signed(out_data)), longint'($signed(held)));
    end
    held_v = out_valid && !out_ready;
    held   = out_data;
    check(in_ready === (!out_valid || out_ready), "R6 ready rule", longint'(in_ready), longint'(!out_valid || out_ready));
    if (in_valid && in_ready) begin
      check(int'(ref_idx) == k % M, "R2 phase index", longint'(ref_idx), longint'(k % M));
      prods[k] = longint'($signed(in_data)) * longint'(reftab(k % M, xmode));
      if (k >= N - 1) begin
        longint s = 0;
        for (int j = k - N + 1; j <= k; j++) s += prods[j];
        expq[tail] = s >>> LGN;
        tail++;
      end
      k++;
    end
    if (out_valid && out_ready) begin
      check(head < tail, "R4 unexpected output", longint'(head), longint'(tail));
      if (head < tail) begin
        check(longint'($signed(out_data)) == expq[head], "R3 R5 window mean",
              longint'($signed(out_data)), expq[head]);
        head++;
      end
      outs++;
      last_out = longint'($signed(out_data));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    k = 0; head = 0; tail = 0; outs = 0; held_v = 0;
    #1;
    check(out_valid === 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(ref_idx === '0, "R1 ref_idx", longint'(ref_idx), 0);
    check(in_ready === 1'b1, "R1 in_ready", longint'(in_ready), 1);
  endtask

  task automatic drain_and_count(input string tag);
    for (int c = 0; c < 4; c++) step(1'b0, 8'hA5, 1'b1);
    check(head == tail, "R4 all outputs delivered", longint'(head), longint'(tail));
    check(outs == ((k >= N) ? k - N + 1 : 0), "R4 output count", longint'(outs),
          longint'((k >= N) ? k - N + 1 : 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // steady streaming
    for (int c = 0; c < 60; c++) step(1'b1, DW'(c * 37 + 5), 1'b1);
    // irregular valid and ready, garbage on idle cycles
    for (int c = 0; c < 400; c++)
      step((c % 4) != 1, DW'(c * 73 + 19), (c % 3) != 0);
    drain_and_count("mixed");

    // mid-run reset, refill phase
    for (int c = 0; c < 10; c++) step(1'b1, DW'(c * 11 + 3), 1'b1);
    do_reset();
    for (int c = 0; c < N - 1; c++) step(1'b1, DW'(c * 29 + 1), 1'b1);
    step(1'b0, 8'h00, 1'b1);
    check(out_valid === 1'b0, "R4 no output before window full", longint'(out_valid), 0);
    step(1'b1, 8'd100, 1'b1);
    step(1'b0, 8'h00, 1'b0);
    check(out_valid === 1'b1, "R4 first output at Nth sample", longint'(out_valid), 1);
    drain_and_count("refill");

    // extreme products
    xmode = 1;
    for (int c = 0; c < 2 * N; c++) step(1'b1, 8'h80, 1'b1);
    drain_and_count("neg");
    check(last_out == 16384, "R8 max positive window", last_out, 16384);
    for (int c = 0; c < 2 * N; c++) step(1'b1, 8'h7F, 1'b1);
    drain_and_count("pos");
    check(last_out == -16256, "R8 max negative window", last_out, -16256);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule